// File: doc/BRIEF.md
# Seven-State Toggle Sequence Counter

This block is a free-running 3-bit synchronous counter. Its bits, named C (most significant), B and A (least significant), step through a fixed cycle of seven codes. Each step happens on a rising clock edge while the count enable is high. The code 000 is never part of the cycle. The counter is built from three T-type storage bits, each updated as `q <= q ^ t`. A decoder turns the present code into three toggle enables; the next code is never assigned directly.

The cycle is 001 → 011 → 010 → 110 → 111 → 101 → 100 and back to 001. The named states are S1=001, S2=011, S3=010, S4=110, S5=111, S6=101 and S7=100. The unused code is ILLEGAL=000. Its single transition, ILLEGAL → S1, lets the counter start on its own from any power-up value. A flag output is high whenever the present code is 000.

Top module: `seq7_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the state loads 001 (C=0, B=0, A=1) and `illegal_o` is low afterwards.
- R2: With `cnt_en` high and no reset, each rising edge moves the state to its successor in the order 001, 011, 010, 110, 111, 101, 100, then 001.
- R3: With `cnt_en` low and no reset, every toggle enable is zero and the state holds across any number of edges, including while it is 000.
- R4: From 000 with `cnt_en` high, one rising edge moves the state to 001.
- R5: `illegal_o` is high exactly while `state_q` equals 000, combinationally and with no clock delay.
- R6: From any legal code, exactly seven enabled edges return the counter to that code, and the walk never visits 000.
- R7: `rst` takes priority over `cnt_en`: a reset edge loads 001 even when counting is enabled.
- R8: Every enabled, non-reset edge changes at least one and at most two state bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset, loads 001 |
| cnt_en | input | 1 | Count enable; when low the state holds |
| state_q | output | 3 | Present code, bit 2 = C, bit 1 = B, bit 0 = A |
| illegal_o | output | 1 | High while the present code is 000 |

## Verification
All state is visible directly at `state_q`, so a wrong toggle decode shows up one edge after the bad state is entered. It appears as a successor that breaks the sequence, or as an entry into 000 that raises `illegal_o` in the same cycle. A counter that does not self-start would stay at 000 with the flag high on the edge after counting is enabled. A cycle that is too short or too long shows within seven enabled edges, because the start code then reappears early or fails to reappear.

// File: rtl/seq7_pkg.sv
package seq7_pkg;

    localparam int SEQ_W = 3;

    typedef enum logic [SEQ_W-1:0] {
        ST_ILLEGAL = 3'b000,
        ST_S1      = 3'b001,
        ST_S2      = 3'b011,
        ST_S3      = 3'b010,
        ST_S4      = 3'b110,
        ST_S5      = 3'b111,
        ST_S6      = 3'b101,
        ST_S7      = 3'b100
    } seq_code_e;

    localparam logic [SEQ_W-1:0] SEQ_START = ST_S1;

    // Successor as a direct code map; used by checks, not by the datapath.
    function automatic logic [SEQ_W-1:0] seq_successor(input logic [SEQ_W-1:0] code);
        logic [SEQ_W-1:0] nxt;
        case (code)
            3'b001:  nxt = 3'b011;
            3'b011:  nxt = 3'b010;
            3'b010:  nxt = 3'b110;
            3'b110:  nxt = 3'b111;
            3'b111:  nxt = 3'b101;
            3'b101:  nxt = 3'b100;
            3'b100:  nxt = 3'b001;
            default: nxt = 3'b001;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/seq7_toggle_gen.sv
module seq7_toggle_gen
    import seq7_pkg::*;
(
    input  logic [SEQ_W-1:0] cur_i,
    input  logic             en_i,
    output logic [SEQ_W-1:0] tgl_o
);

    seq_code_e        cur_code;
    logic [SEQ_W-1:0] raw_tgl;

    assign cur_code = seq_code_e'(cur_i);

    // Per-state toggle pattern: bits that must flip to reach the successor.
    always_comb begin
        unique case (cur_code)
            ST_S1:      raw_tgl = 3'b010;  // S1 -> S2
            ST_S2:      raw_tgl = 3'b001;  // S2 -> S3
            ST_S3:      raw_tgl = 3'b100;  // S3 -> S4
            ST_S4:      raw_tgl = 3'b001;  // S4 -> S5
            ST_S5:      raw_tgl = 3'b010;  // S5 -> S6
            ST_S6:      raw_tgl = 3'b001;  // S6 -> S7
            ST_S7:      raw_tgl = 3'b101;  // S7 -> S1
            ST_ILLEGAL: raw_tgl = 3'b001;  // ILLEGAL -> S1
        endcase
    end

    assign tgl_o = en_i ? raw_tgl : '0;

endmodule

// File: rtl/seq7_tbit.sv
module seq7_tbit #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic tgl_i,
    output logic q_o
);

    logic q_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= RST_VAL;
        end else begin
            q_r <= q_r ^ tgl_i;
        end
    end

    assign q_o = q_r;

    AST_TBIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tgl_i |=> $stable(q_r)); // R3

endmodule

// File: rtl/seq7_counter.sv
module seq7_counter
    import seq7_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    output logic [SEQ_W-1:0] state_q,
    output logic             illegal_o
);

    logic [SEQ_W-1:0] tgl;
    logic [SEQ_W-1:0] bits_q;

    seq7_toggle_gen u_tgl (
        .cur_i (bits_q),
        .en_i  (cnt_en),
        .tgl_o (tgl)
    );

    generate
        for (genvar i = 0; i < SEQ_W; i++) begin : g_bit
            seq7_tbit #(
                .RST_VAL (SEQ_START[i])
            ) u_bit (
                .clk   (clk),
                .rst   (rst),
                .tgl_i (tgl[i]),
                .q_o   (bits_q[i])
            );
        end
    endgenerate

    // Output process
    always_comb begin
        state_q   = bits_q;
        illegal_o = (bits_q == ST_ILLEGAL);
    end

    AST_STEP_ORDER: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !illegal_o) |=> (state_q == seq_successor($past(state_q)))); // R2

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> $stable(state_q)); // R3

    AST_SELF_START: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && state_q == 3'b000) |=> (state_q == 3'b001)); // R4

    AST_NEVER_ENTER: assert property (@(posedge clk) disable iff (rst)
        !illegal_o |=> !illegal_o); // R6

    AST_BIT_CHANGES: assert property (@(posedge clk) disable iff (rst)
        cnt_en |=> ($countones(state_q ^ $past(state_q)) >= 1 &&
                    $countones(state_q ^ $past(state_q)) <= 2)); // R8

endmodule

// File: tb/tb_seq7_counter.sv
module tb_seq7_counter;

    typedef struct {
        logic [2:0] code;
        logic       flag;
        string      tag;
    } exp_item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_en = 1'b0;
    logic [2:0] state_q;
    logic       illegal_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    exp_item_t exp_q[$];

    localparam logic [2:0] ORDER [7] = '{3'b001, 3'b011, 3'b010, 3'b110,
                                         3'b111, 3'b101, 3'b100};

    always #4 clk = ~clk;  // 125 MHz

    seq7_counter dut (
        .clk       (clk),
        .rst       (rst),
        .cnt_en    (cnt_en),
        .state_q   (state_q),
        .illegal_o (illegal_o)
    );

    // Driver: set inputs at a falling edge and queue the result due after the next rising edge.
    task automatic drive(input logic r, input logic e, input logic [2:0] code,
                         input logic flag, input string tag);
        exp_item_t it;
        @(negedge clk);
        rst    = r;
        cnt_en = e;
        it.code = code;
        it.flag = flag;
        it.tag  = tag;
        exp_q.push_back(it);
    endtask

    // Monitor: sample 2 ns after each rising edge.
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_item_t it;
            it = exp_q.pop_front();
            checks++;
            if (state_q !== it.code || illegal_o !== it.flag) begin
                errors++;
                $display("FAIL %s: state=%b flag=%b expected state=%b flag=%b",
                         it.tag, state_q, illegal_o, it.code, it.flag);
            end
        end
    end

    task automatic direct_check(input logic cond, input string tag,
                                input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset loads 001
        drive(1'b1, 1'b0, 3'b001, 1'b0, "R1 reset");
        drive(1'b1, 1'b0, 3'b001, 1'b0, "R1 reset held");

        // R2, R6, R8: seven enabled edges walk the cycle and return to 001
        for (int k = 0; k < 7; k++) begin
            drive(1'b0, 1'b1, ORDER[(k + 1) % 7], 1'b0, "R2 R6 R8 walk");
        end

        // R3: hold with enable low
        for (int k = 0; k < 3; k++) begin
            drive(1'b0, 1'b0, 3'b001, 1'b0, "R3 hold");
        end

        // R6: second lap starting from a different code
        drive(1'b0, 1'b1, 3'b011, 1'b0, "R2 step");
        drive(1'b0, 1'b1, 3'b010, 1'b0, "R2 step");
        for (int k = 0; k < 7; k++) begin
            drive(1'b0, 1'b1, ORDER[(k + 3) % 7], 1'b0, "R6 lap from 010");
        end

        // R7: reset beats enable mid-cycle
        drive(1'b0, 1'b1, 3'b110, 1'b0, "R2 step");
        drive(1'b1, 1'b1, 3'b001, 1'b0, "R7 reset priority");

        // Force the unused code while reset is held, then release and hold it
        drive(1'b1, 1'b0, 3'b001, 1'b0, "R1 reset before force");
        @(negedge clk);
        force dut.g_bit[0].u_bit.q_r = 1'b0;
        force dut.g_bit[1].u_bit.q_r = 1'b0;
        force dut.g_bit[2].u_bit.q_r = 1'b0;
        #1;
        release dut.g_bit[0].u_bit.q_r;
        release dut.g_bit[1].u_bit.q_r;
        release dut.g_bit[2].u_bit.q_r;
        rst    = 1'b0;
        cnt_en = 1'b0;
        #1;
        direct_check(state_q == 3'b000 && illegal_o == 1'b1, "R5 flag on 000",
                     {state_q, illegal_o}, 4'b0001);
        begin
            exp_item_t it;
            it.code = 3'b000;
            it.flag = 1'b1;
            it.tag  = "R3 R5 hold at 000";
            exp_q.push_back(it);
        end
        drive(1'b0, 1'b0, 3'b000, 1'b1, "R3 R5 hold at 000");
        drive(1'b0, 1'b1, 3'b001, 1'b0, "R4 self-start");
        drive(1'b0, 1'b1, 3'b011, 1'b0, "R5 flag clear / R2 step");

        drive(1'b0, 1'b0, 3'b011, 1'b0, "R3 hold");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule